// File: doc/BRIEF.md
# Scoped-Invalidation Translation Cache

This block is a small, fully associative cache of address translations for an I/O memory management unit. Each entry pairs a lookup key with a result. The key is an address-space identifier and an input virtual address. The result is an output address, an address mask and a permission field. A page-table walker, which lives outside this block, fills the cache through the insert port. Device traffic queries the cache through the lookup port. Software-driven maintenance removes stale translations through the invalidation port.

A lookup returns a registered result one cycle after its request. The result reflects the cache contents as they stood in the request cycle. Invalidation has three scopes:

- the whole cache;
- every entry of one identifier;
- one exact identifier-and-address pair.

Any invalidation completes in a single cycle. An invalidation overrides an insert presented in the same cycle. Inserting a key that is already stored rewrites that entry in place. Otherwise, free slots are used lowest index first. Once the cache is full, a round-robin pointer chooses the victim.

Top module: `xlat_cache`

## Requirements
- R1: A lookup hits only when a valid entry stores both the same identifier and the same address. On a hit it returns that entry's output address, mask and permission. On a miss those three outputs read zero.
- R2: `lk_vld` is high in the cycle after a cycle with `lk_req` high. The result in that cycle reflects the contents before any insert or invalidation issued in the request cycle.
- R3: An invalidation with kind code 0 removes every entry.
- R4: An invalidation with kind code 1 removes every entry whose identifier equals `inv_id`, whatever its address. Other identifiers are untouched.
- R5: An invalidation with kind code 2 removes only the entry whose identifier equals `inv_id` and whose address equals `inv_va`.
- R6: Reset, including a reset applied mid-operation, empties the cache and returns the replacement pointer to slot 0.
- R7: An accepted insert makes its key hit from the next cycle on, returning the inserted output address, mask and permission.
- R8: When `inv_req` is high, an insert in the same cycle is discarded. Lookups in the following cycle already see the invalidation's effect.
- R9: An insert with a new key takes the lowest-numbered free slot. When no slot is free, it replaces the slot named by a pointer that starts at 0 and advances by one, modulo 8, on each such replacement.
- R10: Inserting a key that is already stored overwrites that entry, so no key is ever stored twice.
- R11: Kind code 3 removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_id | input | 16 | Lookup identifier |
| lk_va | input | 64 | Lookup input address |
| lk_vld | output | 1 | Lookup result valid (one cycle after request) |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 64 | Translated output address |
| lk_mask | output | 64 | Address mask of the hit entry |
| lk_perm | output | 2 | Permission bits of the hit entry |
| ins_req | input | 1 | Insert request |
| ins_id | input | 16 | Insert identifier |
| ins_va | input | 64 | Insert input address |
| ins_pa | input | 64 | Insert output address |
| ins_mask | input | 64 | Insert address mask |
| ins_perm | input | 2 | Insert permission bits |
| inv_req | input | 1 | Invalidation request |
| inv_kind | input | 2 | 0 all, 1 by identifier, 2 exact pair, 3 none |
| inv_id | input | 16 | Invalidation identifier |
| inv_va | input | 64 | Invalidation address (exact scope only) |

## Verification
The assertions assume that every request and key input carries a known value at each clock edge. They place no restriction on combining lookup, insert and invalidation in one cycle, and every kind code is legal.

The stimulus stays inside this by driving only defined values at the falling edge. It draws identifiers from a pool of four and addresses from a pool of twelve, so exact repeats, identifier-only collisions and a full cache all occur often. Invalidations are kept rare enough that the cache regularly fills and the round-robin replacement is exercised.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int unsigned XL_ENTRIES = 8;
  localparam int unsigned XL_ID_W    = 16;
  localparam int unsigned XL_VA_W    = 64;
  localparam int unsigned XL_PA_W    = 64;
  localparam int unsigned XL_PERM_W  = 2;

  typedef enum logic [1:0] {
    INV_ALL   = 2'd0,
    INV_BY_ID = 2'd1,
    INV_EXACT = 2'd2,
    INV_NONE  = 2'd3
  } inv_kind_e;

endpackage

// File: rtl/xlat_tag_match.sv
module xlat_tag_match #(
  parameter int unsigned N    = 8,
  parameter int unsigned ID_W = 16,
  parameter int unsigned VA_W = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N-1:0]              ent_vld,
  input  logic [N-1:0][ID_W-1:0]    ent_id,
  input  logic [N-1:0][VA_W-1:0]    ent_va,
  input  logic [ID_W-1:0]           lk_id,
  input  logic [VA_W-1:0]           lk_va,
  input  logic [ID_W-1:0]           ins_id,
  input  logic [VA_W-1:0]           ins_va,
  input  logic [ID_W-1:0]           inv_id,
  input  logic [VA_W-1:0]           inv_va,
  output logic [N-1:0]              lk_hit_vec,
  output logic [N-1:0]              ins_hit_vec,
  output logic [N-1:0]              inv_id_vec,
  output logic [N-1:0]              inv_exact_vec
);

  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic lk_id_eq, lk_va_eq, ins_id_eq, ins_va_eq, inv_id_eq, inv_va_eq;
    assign lk_id_eq  = (ent_id[i] == lk_id);
    assign lk_va_eq  = (ent_va[i] == lk_va);
    assign ins_id_eq = (ent_id[i] == ins_id);
    assign ins_va_eq = (ent_va[i] == ins_va);
    assign inv_id_eq = (ent_id[i] == inv_id);
    assign inv_va_eq = (ent_va[i] == inv_va);

    assign lk_hit_vec[i]    = ent_vld[i] & lk_id_eq  & lk_va_eq;
    assign ins_hit_vec[i]   = ent_vld[i] & ins_id_eq & ins_va_eq;
    assign inv_id_vec[i]    = ent_vld[i] & inv_id_eq;
    assign inv_exact_vec[i] = ent_vld[i] & inv_id_eq & inv_va_eq;
  end

  // R10: stored keys are unique, so any probe matches at most one slot
  a_r10_unique_lookup_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_vec));
  a_r10_unique_insert_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ins_hit_vec));

endmodule

// File: rtl/xlat_victim_sel.sv
module xlat_victim_sel #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ins_fire,
  input  logic [N-1:0] ent_vld,
  input  logic [N-1:0] ins_hit_vec,
  output logic [N-1:0] wr_vec
);

  localparam int unsigned PTR_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(N - 1);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;
  logic [N-1:0]     free_vec, low_free, ptr_vec;
  logic             any_hit, any_free, replace;

  always_comb begin
    free_vec = ~ent_vld;
    low_free = free_vec & (~free_vec + N'(1));
    ptr_vec  = N'(1) << ptr_q;
    any_hit  = |ins_hit_vec;
    any_free = |free_vec;
    replace  = ins_fire & ~any_hit & ~any_free;

    if (any_hit)       wr_vec = ins_hit_vec;
    else if (any_free) wr_vec = low_free;
    else               wr_vec = ptr_vec;

    ptr_en = replace;
    ptr_d  = (ptr_q == PTR_LAST) ? '0 : ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  // R9: the selected write slot is always a single slot
  a_r9_single_victim: assert property (@(posedge clk) disable iff (!rst_n)
    ins_fire |-> $onehot(wr_vec));
  // R9: a replacement in a full cache moves the pointer on
  a_r9_ptr_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_fire && !any_hit && (&ent_vld)) |=> (ptr_q != $past(ptr_q)));
  // R9: without a replacement the pointer holds
  a_r9_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(ins_fire && !any_hit && (&ent_vld)) |=> $stable(ptr_q));

endmodule

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int unsigned N      = 8,
  parameter int unsigned ID_W   = 16,
  parameter int unsigned VA_W   = 64,
  parameter int unsigned PA_W   = 64,
  parameter int unsigned PERM_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ins_fire,
  input  logic [N-1:0]              wr_vec,
  input  logic [ID_W-1:0]           ins_id,
  input  logic [VA_W-1:0]           ins_va,
  input  logic [PA_W-1:0]           ins_pa,
  input  logic [PA_W-1:0]           ins_mask,
  input  logic [PERM_W-1:0]         ins_perm,
  input  logic                      inv_fire,
  input  logic [1:0]                inv_kind,
  input  logic [N-1:0]              inv_id_vec,
  input  logic [N-1:0]              inv_exact_vec,
  output logic [N-1:0]              ent_vld,
  output logic [N-1:0][ID_W-1:0]    ent_id,
  output logic [N-1:0][VA_W-1:0]    ent_va,
  output logic [N-1:0][PA_W-1:0]    ent_pa,
  output logic [N-1:0][PA_W-1:0]    ent_mask,
  output logic [N-1:0][PERM_W-1:0]  ent_perm
);

  logic [N-1:0] vld_q, vld_d;
  logic         vld_en;
  inv_kind_e    kind;

  assign kind = inv_kind_e'(inv_kind);

  always_comb begin
    vld_d  = vld_q;
    vld_en = inv_fire | ins_fire;
    if (inv_fire) begin
      unique case (kind)
        INV_ALL:   vld_d = '0;
        INV_BY_ID: vld_d = vld_q & ~inv_id_vec;
        INV_EXACT: vld_d = vld_q & ~inv_exact_vec;
        default:   vld_d = vld_q;
      endcase
    end else if (ins_fire) begin
      vld_d = vld_q | wr_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vld_q <= '0;
    else if (vld_en) vld_q <= vld_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic slot_en;
    assign slot_en = ins_fire & wr_vec[i];
    always_ff @(posedge clk) begin
      if (slot_en) begin
        ent_id[i]   <= ins_id;
        ent_va[i]   <= ins_va;
        ent_pa[i]   <= ins_pa;
        ent_mask[i] <= ins_mask;
        ent_perm[i] <= ins_perm;
      end
    end
  end

  assign ent_vld = vld_q;

  // Checker state: key of the last accepted insert
  logic            chk_pend_q;
  logic [ID_W-1:0] chk_id_q;
  logic [VA_W-1:0] chk_va_q;
  logic            chk_found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_pend_q <= 1'b0;
      chk_id_q   <= '0;
      chk_va_q   <= '0;
    end else begin
      chk_pend_q <= ins_fire;
      chk_id_q   <= ins_id;
      chk_va_q   <= ins_va;
    end
  end

  always_comb begin
    chk_found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (vld_q[i] && ent_id[i] == chk_id_q && ent_va[i] == chk_va_q) chk_found = 1'b1;
    end
  end

  // R7: an accepted insert is present in the following cycle
  a_r7_insert_present: assert property (@(posedge clk) disable iff (!rst_n)
    chk_pend_q |-> chk_found);
  // R3: full invalidation leaves nothing valid
  a_r3_all_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_fire && kind == INV_ALL) |=> (vld_q == '0));
  // R4: no entry of the named identifier survives
  a_r4_id_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_fire && kind == INV_BY_ID) |=> ((vld_q & $past(inv_id_vec)) == '0));
  // R5: exact invalidation removes at most one entry
  a_r5_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_fire && kind == INV_EXACT) |=>
      ($countones(vld_q) + 1 >= $past($countones(vld_q))));
  // R8: an invalidation cycle never adds an entry
  a_r8_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    inv_fire |=> ((vld_q & ~$past(vld_q)) == '0));
  // R11: the no-op kind leaves the valid set alone
  a_r11_none_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_fire && kind == INV_NONE) |=> $stable(vld_q));

endmodule

// File: rtl/xlat_result_reg.sv
module xlat_result_reg #(
  parameter int unsigned N      = 8,
  parameter int unsigned PA_W   = 64,
  parameter int unsigned PERM_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      lk_req,
  input  logic [N-1:0]              lk_hit_vec,
  input  logic [N-1:0][PA_W-1:0]    ent_pa,
  input  logic [N-1:0][PA_W-1:0]    ent_mask,
  input  logic [N-1:0][PERM_W-1:0]  ent_perm,
  output logic                      lk_vld,
  output logic                      lk_hit,
  output logic [PA_W-1:0]           lk_pa,
  output logic [PA_W-1:0]           lk_mask,
  output logic [PERM_W-1:0]         lk_perm
);

  logic              hit_d;
  logic [PA_W-1:0]   pa_d, mask_d;
  logic [PERM_W-1:0] perm_d;

  always_comb begin
    hit_d  = lk_req & (|lk_hit_vec);
    pa_d   = '0;
    mask_d = '0;
    perm_d = '0;
    for (int i = 0; i < N; i++) begin
      pa_d   = pa_d   | ({PA_W{lk_hit_vec[i]}}   & ent_pa[i]);
      mask_d = mask_d | ({PA_W{lk_hit_vec[i]}}   & ent_mask[i]);
      perm_d = perm_d | ({PERM_W{lk_hit_vec[i]}} & ent_perm[i]);
    end
    if (!hit_d) begin
      pa_d   = '0;
      mask_d = '0;
      perm_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_vld  <= 1'b0;
      lk_hit  <= 1'b0;
      lk_pa   <= '0;
      lk_mask <= '0;
      lk_perm <= '0;
    end else begin
      lk_vld  <= lk_req;
      lk_hit  <= hit_d;
      lk_pa   <= pa_d;
      lk_mask <= mask_d;
      lk_perm <= perm_d;
    end
  end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int unsigned ENTRIES = XL_ENTRIES,
  parameter int unsigned ID_W    = XL_ID_W,
  parameter int unsigned VA_W    = XL_VA_W,
  parameter int unsigned PA_W    = XL_PA_W,
  parameter int unsigned PERM_W  = XL_PERM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [ID_W-1:0]   lk_id,
  input  logic [VA_W-1:0]   lk_va,
  output logic              lk_vld,
  output logic              lk_hit,
  output logic [PA_W-1:0]   lk_pa,
  output logic [PA_W-1:0]   lk_mask,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              ins_req,
  input  logic [ID_W-1:0]   ins_id,
  input  logic [VA_W-1:0]   ins_va,
  input  logic [PA_W-1:0]   ins_pa,
  input  logic [PA_W-1:0]   ins_mask,
  input  logic [PERM_W-1:0] ins_perm,
  input  logic              inv_req,
  input  logic [1:0]        inv_kind,
  input  logic [ID_W-1:0]   inv_id,
  input  logic [VA_W-1:0]   inv_va
);

  logic                            ins_fire, inv_fire;
  logic [ENTRIES-1:0]              ent_vld, lk_hit_vec, ins_hit_vec;
  logic [ENTRIES-1:0]              inv_id_vec, inv_exact_vec, wr_vec;
  logic [ENTRIES-1:0][ID_W-1:0]    ent_id;
  logic [ENTRIES-1:0][VA_W-1:0]    ent_va;
  logic [ENTRIES-1:0][PA_W-1:0]    ent_pa, ent_mask;
  logic [ENTRIES-1:0][PERM_W-1:0]  ent_perm;

  assign inv_fire = inv_req;
  assign ins_fire = ins_req & ~inv_req;

  xlat_tag_match #(.N(ENTRIES), .ID_W(ID_W), .VA_W(VA_W)) u_match (
    .clk(clk), .rst_n(rst_n),
    .ent_vld(ent_vld), .ent_id(ent_id), .ent_va(ent_va),
    .lk_id(lk_id), .lk_va(lk_va),
    .ins_id(ins_id), .ins_va(ins_va),
    .inv_id(inv_id), .inv_va(inv_va),
    .lk_hit_vec(lk_hit_vec), .ins_hit_vec(ins_hit_vec),
    .inv_id_vec(inv_id_vec), .inv_exact_vec(inv_exact_vec)
  );

  xlat_victim_sel #(.N(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n),
    .ins_fire(ins_fire), .ent_vld(ent_vld),
    .ins_hit_vec(ins_hit_vec), .wr_vec(wr_vec)
  );

  xlat_store #(.N(ENTRIES), .ID_W(ID_W), .VA_W(VA_W), .PA_W(PA_W), .PERM_W(PERM_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ins_fire(ins_fire), .wr_vec(wr_vec),
    .ins_id(ins_id), .ins_va(ins_va), .ins_pa(ins_pa),
    .ins_mask(ins_mask), .ins_perm(ins_perm),
    .inv_fire(inv_fire), .inv_kind(inv_kind),
    .inv_id_vec(inv_id_vec), .inv_exact_vec(inv_exact_vec),
    .ent_vld(ent_vld), .ent_id(ent_id), .ent_va(ent_va),
    .ent_pa(ent_pa), .ent_mask(ent_mask), .ent_perm(ent_perm)
  );

  xlat_result_reg #(.N(ENTRIES), .PA_W(PA_W), .PERM_W(PERM_W)) u_result (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_hit_vec(lk_hit_vec),
    .ent_pa(ent_pa), .ent_mask(ent_mask), .ent_perm(ent_perm),
    .lk_vld(lk_vld), .lk_hit(lk_hit), .lk_pa(lk_pa),
    .lk_mask(lk_mask), .lk_perm(lk_perm)
  );

  // R2: a result is only reported in the cycle after a request
  a_r2_result_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !lk_hit);
  // R8: an insert beside an invalidation does not land
  a_r8_insert_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && ins_req) |=> ((ent_vld & ~$past(ent_vld)) == '0));

endmodule

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0;
  logic [15:0] lk_id = '0;
  logic [63:0] lk_va = '0;
  logic        lk_vld, lk_hit;
  logic [63:0] lk_pa, lk_mask;
  logic [1:0]  lk_perm;
  logic        ins_req = 1'b0;
  logic [15:0] ins_id = '0;
  logic [63:0] ins_va = '0, ins_pa = '0, ins_mask = '0;
  logic [1:0]  ins_perm = '0;
  logic        inv_req = 1'b0;
  logic [1:0]  inv_kind = '0;
  logic [15:0] inv_id = '0;
  logic [63:0] inv_va = '0;

  always #5 clk = ~clk;

  xlat_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_id(lk_id), .lk_va(lk_va),
    .lk_vld(lk_vld), .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_mask(lk_mask), .lk_perm(lk_perm),
    .ins_req(ins_req), .ins_id(ins_id), .ins_va(ins_va), .ins_pa(ins_pa),
    .ins_mask(ins_mask), .ins_perm(ins_perm),
    .inv_req(inv_req), .inv_kind(inv_kind), .inv_id(inv_id), .inv_va(inv_va)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference model
  bit          m_vld [N];
  logic [15:0] m_id  [N];
  logic [63:0] m_va  [N];
  logic [63:0] m_pa  [N];
  logic [63:0] m_mask[N];
  logic [1:0]  m_perm[N];
  int          m_ptr;

  function automatic int m_find(logic [15:0] id, logic [63:0] va);
    for (int i = 0; i < N; i++) if (m_vld[i] && m_id[i] == id && m_va[i] == va) return i;
    return -1;
  endfunction

  function automatic void m_clear();
    for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
    m_ptr = 0;
  endfunction

  function automatic int m_slot(logic [15:0] id, logic [63:0] va);
    int s;
    s = m_find(id, va);
    if (s >= 0) return s;
    for (int i = 0; i < N; i++) if (!m_vld[i]) return i;
    s = m_ptr;
    m_ptr = (m_ptr + 1) % N;
    return s;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    lk_req = 0; ins_req = 0; inv_req = 0;
  endtask

  // one cycle: expected lookup from pre-edge model, model update, compare after edge
  task automatic step(string tag);
    bit e_vld, e_hit;
    logic [63:0] e_pa, e_mask;
    logic [1:0] e_perm;
    int idx, s;
    e_vld = lk_req;
    idx = lk_req ? m_find(lk_id, lk_va) : -1;
    e_hit = (idx >= 0);
    e_pa = e_hit ? m_pa[idx] : '0;
    e_mask = e_hit ? m_mask[idx] : '0;
    e_perm = e_hit ? m_perm[idx] : '0;
    if (inv_req) begin
      for (int i = 0; i < N; i++) begin
        case (inv_kind)
          2'd0: m_vld[i] = 1'b0;
          2'd1: if (m_id[i] == inv_id) m_vld[i] = 1'b0;
          2'd2: if (m_id[i] == inv_id && m_va[i] == inv_va) m_vld[i] = 1'b0;
          default: ;
        endcase
      end
    end else if (ins_req) begin
      s = m_slot(ins_id, ins_va);
      m_vld[s] = 1'b1; m_id[s] = ins_id; m_va[s] = ins_va;
      m_pa[s] = ins_pa; m_mask[s] = ins_mask; m_perm[s] = ins_perm;
    end
    @(posedge clk);
    @(negedge clk);
    chk(lk_vld == e_vld, {tag, " R2 vld"}, 64'(lk_vld), 64'(e_vld));
    if (e_vld) begin
      chk(lk_hit == e_hit, {tag, " R1 hit"}, 64'(lk_hit), 64'(e_hit));
      chk(lk_pa == e_pa, {tag, " R1 pa"}, lk_pa, e_pa);
      chk(lk_mask == e_mask, {tag, " R1 mask"}, lk_mask, e_mask);
      chk(lk_perm == e_perm, {tag, " R1 perm"}, 64'(lk_perm), 64'(e_perm));
    end
    idle();
  endtask

  task automatic do_lk(logic [15:0] id, logic [63:0] va, string tag);
    lk_req = 1; lk_id = id; lk_va = va;
    step(tag);
  endtask

  task automatic do_ins(logic [15:0] id, logic [63:0] va, logic [63:0] pa, string tag);
    ins_req = 1; ins_id = id; ins_va = va; ins_pa = pa;
    ins_mask = 64'hFFF; ins_perm = pa[1:0];
    step(tag);
  endtask

  task automatic do_inv(logic [1:0] k, logic [15:0] id, logic [63:0] va, string tag);
    inv_req = 1; inv_kind = k; inv_id = id; inv_va = va;
    step(tag);
  endtask

  task automatic do_reset();
    rst_n = 0;
    m_clear();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  function automatic logic [63:0] kva(int k);
    return 64'(k) * 64'h1000 + ((k % 2) != 0 ? 64'hFFFF_8000_0000_0000 : 64'h0);
  endfunction

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    m_clear();
    idle();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R6: empty after reset
    chk(lk_vld == 0 && lk_hit == 0, "R6 outputs idle", 64'(lk_hit), 0);
    do_lk(1, kva(0), "R6 empty");

    // R7, R9: fill slots 0..7 in order
    for (int k = 0; k < 8; k++) do_ins(1, kva(k), 64'h4000_0000 + 64'(k) * 64'h10001, "R7 fill");
    for (int k = 0; k < 8; k++) do_lk(1, kva(k), "R7 present");
    do_lk(2, kva(3), "R1 other id misses");
    do_lk(1, kva(3) + 64'h8, "R1 other va misses");

    // R2: lookup same cycle as insert sees old contents
    lk_req = 1; lk_id = 3; lk_va = kva(20);
    ins_req = 1; ins_id = 3; ins_va = kva(20); ins_pa = 64'h77; ins_mask = 64'hFFF; ins_perm = 2'd3;
    step("R2 same-cycle insert invisible");   // full: replaces slot 0 (key 0)
    do_lk(3, kva(20), "R2 insert visible next");
    do_lk(1, kva(0), "R9 slot0 evicted");
    do_lk(1, kva(1), "R9 slot1 kept");
    do_ins(3, kva(21), 64'h99, "R9 second replace");  // slot 1
    do_lk(1, kva(1), "R9 slot1 evicted");
    do_lk(1, kva(2), "R9 slot2 kept");

    // R10: overwrite existing key
    do_ins(1, kva(2), 64'hABCD_0002, "R10 overwrite");
    do_lk(1, kva(2), "R10 new data");
    do_ins(2, kva(30), 64'h31, "R10 next replace");  // slot 2 was overwritten in place; this replaces slot 2 per pointer
    do_lk(1, kva(3), "R10 key3 intact");

    // R8, R11: invalidation with no-op kind still drops the insert
    inv_req = 1; inv_kind = 2'd3; inv_id = 1; inv_va = kva(3);
    ins_req = 1; ins_id = 2; ins_va = kva(40); ins_pa = 64'h55; ins_mask = 64'hFFF; ins_perm = 2'd1;
    step("R8 collide");
    do_lk(2, kva(40), "R8 insert dropped");
    do_lk(1, kva(3), "R11 none kept");

    // R5: exact invalidation
    do_inv(2'd2, 1, kva(3), "R5 exact");
    do_lk(1, kva(3), "R5 removed");
    do_lk(1, kva(4), "R5 neighbour kept");
    do_lk(3, kva(20), "R5 other id kept");

    // R4: identifier invalidation
    do_inv(2'd1, 1, 64'h0, "R4 by id");
    do_lk(1, kva(5), "R4 removed");
    do_lk(1, kva(7), "R4 removed b");
    do_lk(3, kva(21), "R4 other id kept");
    do_lk(2, kva(30), "R4 other id kept b");

    // R3: full invalidation
    do_inv(2'd0, 0, 64'h0, "R3 all");
    do_lk(3, kva(20), "R3 removed");
    do_lk(2, kva(30), "R3 removed b");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 100);
      lk_req = (r < 70);
      lk_id = 16'($urandom % 4); lk_va = kva(int'($urandom % 12));
      ins_req = ($urandom % 100) < 45;
      ins_id = 16'($urandom % 4); ins_va = kva(int'($urandom % 12));
      ins_pa = {$urandom, $urandom}; ins_mask = {$urandom, $urandom}; ins_perm = 2'($urandom);
      inv_req = ($urandom % 100) < 6;
      inv_kind = 2'($urandom); inv_id = 16'($urandom % 4); inv_va = kva(int'($urandom % 12));
      step("R9 random");
    end

    // R6: reset mid-run
    for (int k = 0; k < 8; k++) do_ins(5, kva(k), 64'(k), "R6 refill");
    do_reset();
    for (int k = 0; k < 8; k++) do_lk(5, kva(k), "R6 mid-run reset empties");
    for (int k = 0; k < 9; k++) do_ins(6, kva(k), 64'(k) + 64'h100, "R6 ptr restart");
    do_lk(6, kva(0), "R6 ptr back at slot0");
    do_lk(6, kva(8), "R6 newest present");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule